// File: doc/BRIEF.md
# Half-Gates Garbled Gate Evaluator

This block is the arithmetic core of the evaluating party in a two-party garbled-circuit protocol. A controller issues one gate per clock. Each issue carries the two input wire labels, the gate's position in the circuit (its gate index), the destination wire index, a flag that says whether the gate is linear or non-linear, and the two ciphertexts that the garbler produced for that gate. After a fixed number of cycles the block returns the output wire label together with the destination wire index and the gate flag, ready to be written back to a label store.

Linear gates use free-XOR, so the output label is simply the XOR of the input labels and the ciphertext inputs are not used. Non-linear gates use half-gates evaluation. Each half hashes one input label with a tweak taken from the gate index. The hash is a fixed-key block cipher in a feed-forward construction. The cipher is a chain of keyed mixing rounds with one round per pipeline register, and a final register combines the two hashes, the conditional table terms and the linear result. Both gate kinds share the same latency, so results leave in issue order and a new gate can enter on every cycle.

Dependencies between gates are the issuer's concern: a gate must not be issued before the labels it reads are written back.

Top module: `hg_gate_eval`

## Requirements
- R1: When `in_nonlin` is 0 the output label is `in_lbl_a ^ in_lbl_b`, whatever values `in_tbl_g`, `in_tbl_e` and `in_gidx` carry.
- R2: When `in_nonlin` is 1 the output label is `Gh ^ Eh`. Here `Gh = H(A, 2j) ^ (A[0] ? in_tbl_g : 0)` and `Eh = H(B, 2j+1) ^ (B[0] ? (in_tbl_e ^ A) : 0)`, where A and B are the input labels and j is `in_gidx`.
- R3: `H(x, t) = E(z) ^ z`, where `z = (x << 1) ^ t`. The shift is within 128 bits and drops the top bit, and t is zero-extended. E applies rounds r = 0..19 in order. Round r computes `y = s ^ (rotl(KEY, 7r mod 128) ^ r)` and returns `y ^ (rotl(y,1) & rotl(y,8)) ^ rotl(y,2)`. The default KEY is 128'h3c6ef372a54ff53a510e527f9b05688c.
- R4: Bit 0 of a label is its select bit. A ciphertext input affects a non-linear result only when its select bit is 1: `in_tbl_g` needs A[0]=1 and `in_tbl_e` needs B[0]=1.
- R5: A gate issued with `in_valid` at clock edge k shows `out_valid` high in the cycle after edge k+20, which is 21 registers from input to output. This holds for both gate kinds.
- R6: Gates may be issued on consecutive cycles, linear and non-linear mixed in any order. Each one yields exactly one result, and results come out in issue order with no stall or gap.
- R7: Each result carries the `in_dst` and `in_nonlin` values of its own gate on `out_dst` and `out_nonlin`.
- R8: During and right after synchronous reset, `out_valid` is 0 and `out_lbl`, `out_dst` and `out_nonlin` are 0.
- R9: While `out_valid` is 0, `out_lbl`, `out_dst` and `out_nonlin` keep the values of the last result.
- R10: Suppose a garbler uses an offset delta with bit 0 set and false labels A0, B0. It forms `TG = H(A0,2j) ^ H(A0^delta,2j) ^ (B0[0] ? delta : 0)` and `TE = H(B0,2j+1) ^ H(B0^delta,2j+1) ^ A0`. Evaluating an AND gate on the labels of plain inputs a and b then returns the false output label `W0`, XORed with delta when a & b = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue a gate this cycle |
| in_nonlin | input | 1 | 1 = half-gates gate, 0 = free-XOR gate |
| in_gidx | input | 32 | Gate index, source of the hash tweaks |
| in_dst | input | 16 | Destination wire index |
| in_lbl_a | input | 128 | First input wire label |
| in_lbl_b | input | 128 | Second input wire label |
| in_tbl_g | input | 128 | Garbler-half ciphertext |
| in_tbl_e | input | 128 | Evaluator-half ciphertext |
| out_valid | output | 1 | Result present |
| out_nonlin | output | 1 | Gate kind of the result |
| out_dst | output | 16 | Destination wire index of the result |
| out_lbl | output | 128 | Output wire label |

## Verification
The free-XOR path and the two-hash cipher path can both hold gates at the same time, and their results can leave on adjacent cycles. The point is that a short linear gate must never overtake or merge with a long non-linear one. The bench provokes this with back-to-back streams that alternate the two kinds and vary select bits and tweaks. It judges every cycle of the stream: `out_valid` must be exactly 21 edges after each issue, and label, destination and kind must match that gate and no neighbour. A further scenario garbles AND gates from a random offset and checks that all four input combinations decode to the correct output label.

// File: rtl/hg_gate_eval.sv
module hg_gate_eval #(
  parameter int LBL_W  = 128,
  parameter int WIRE_W = 16,
  parameter int GIDX_W = 32,
  parameter int NSTG   = 20,
  parameter logic [LBL_W-1:0] KEY = 128'h3c6e_f372_a54f_f53a_510e_527f_9b05_688c
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_nonlin,
  input  logic [GIDX_W-1:0] in_gidx,
  input  logic [WIRE_W-1:0] in_dst,
  input  logic [LBL_W-1:0]  in_lbl_a,
  input  logic [LBL_W-1:0]  in_lbl_b,
  input  logic [LBL_W-1:0]  in_tbl_g,
  input  logic [LBL_W-1:0]  in_tbl_e,
  output logic              out_valid,
  output logic              out_nonlin,
  output logic [WIRE_W-1:0] out_dst,
  output logic [LBL_W-1:0]  out_lbl
);
  localparam int LAT = NSTG + 1;
  localparam int CW  = $clog2(LAT + 2);

  function automatic logic [LBL_W-1:0] rotl(input logic [LBL_W-1:0] v, input int n);
    int m;
    m = n % LBL_W;
    if (m == 0) return v;
    return (v << m) | (v >> (LBL_W - m));
  endfunction

  function automatic logic [LBL_W-1:0] mix(input logic [LBL_W-1:0] s, input int r);
    logic [LBL_W-1:0] y;
    y = s ^ rotl(KEY, 7 * r) ^ LBL_W'(r);
    return y ^ (rotl(y, 1) & rotl(y, 8)) ^ rotl(y, 2);
  endfunction

  // entry: tweaks, doubled labels, select-bit masks, free-XOR result
  logic [LBL_W-1:0] tw_g, tw_e, x_g, x_e, mask, side_in;
  assign tw_g    = LBL_W'({in_gidx, 1'b0});
  assign tw_e    = LBL_W'({in_gidx, 1'b1});
  assign x_g     = {in_lbl_a[LBL_W-2:0], 1'b0} ^ tw_g;
  assign x_e     = {in_lbl_b[LBL_W-2:0], 1'b0} ^ tw_e;
  assign mask    = (in_lbl_a[0] ? in_tbl_g : '0) ^ (in_lbl_b[0] ? (in_tbl_e ^ in_lbl_a) : '0);
  assign side_in = in_nonlin ? (x_g ^ x_e ^ mask) : (in_lbl_a ^ in_lbl_b);

  // cipher pipeline, one round per register, two lanes plus one side word
  logic [LBL_W-1:0]  st_g [NSTG];
  logic [LBL_W-1:0]  st_e [NSTG];
  logic [LBL_W-1:0]  side [NSTG];
  logic [WIRE_W-1:0] dst  [NSTG];
  logic [NSTG-1:0]   vld, nl;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[NSTG-2:0], in_valid};
    nl      <= {nl[NSTG-2:0], in_nonlin};
    st_g[0] <= mix(x_g, 0);
    st_e[0] <= mix(x_e, 0);
    side[0] <= side_in;
    dst[0]  <= in_dst;
    for (int i = 1; i < NSTG; i++) begin
      st_g[i] <= mix(st_g[i-1], i);
      st_e[i] <= mix(st_e[i-1], i);
      side[i] <= side[i-1];
      dst[i]  <= dst[i-1];
    end
  end

  // combine stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_nonlin <= 1'b0;
      out_dst    <= '0;
      out_lbl    <= '0;
    end else begin
      out_valid <= vld[NSTG-1];
      if (vld[NSTG-1]) begin
        out_nonlin <= nl[NSTG-1];
        out_dst    <= dst[NSTG-1];
        out_lbl    <= nl[NSTG-1] ? (st_g[NSTG-1] ^ st_e[NSTG-1] ^ side[NSTG-1])
                                 : side[NSTG-1];
      end
    end
  end

  // occupancy and quiet-time trackers for the checks below
  logic [CW-1:0] inflight, quiet;
  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= '0;
      quiet    <= CW'(LAT);
    end else begin
      inflight <= inflight + CW'(in_valid) - CW'(out_valid);
      if (in_valid)             quiet <= '0;
      else if (quiet < CW'(LAT)) quiet <= quiet + 1'b1;
    end
  end

  a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  a_r5_drained: assert property (@(posedge clk) disable iff (rst)
    (quiet >= CW'(LAT)) |-> !out_valid);

  a_r6_no_phantom: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != '0));

  a_r6_capacity: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(LAT));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_lbl) && $stable(out_dst) && $stable(out_nonlin)));
endmodule

// File: tb/tb_hg_gate_eval.sv
module tb_hg_gate_eval;
  localparam int LAT = 21;
  localparam logic [127:0] KEY = 128'h3c6e_f372_a54f_f53a_510e_527f_9b05_688c;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0, in_nonlin = 1'b0;
  logic [31:0]  in_gidx = '0;
  logic [15:0]  in_dst = '0;
  logic [127:0] in_lbl_a = '0, in_lbl_b = '0, in_tbl_g = '0, in_tbl_e = '0;
  logic         out_valid, out_nonlin;
  logic [15:0]  out_dst;
  logic [127:0] out_lbl;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hg_gate_eval dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_nonlin(in_nonlin),
    .in_gidx(in_gidx), .in_dst(in_dst), .in_lbl_a(in_lbl_a), .in_lbl_b(in_lbl_b),
    .in_tbl_g(in_tbl_g), .in_tbl_e(in_tbl_e), .out_valid(out_valid),
    .out_nonlin(out_nonlin), .out_dst(out_dst), .out_lbl(out_lbl)
  );

  // reference model written from R1..R3
  function automatic logic [127:0] m_rotl(logic [127:0] v, int n);
    int s;
    s = n % 128;
    if (s == 0) return v;
    return (v << s) | (v >> (128 - s));
  endfunction

  function automatic logic [127:0] m_enc(logic [127:0] x);
    logic [127:0] y;
    for (int r = 0; r < 20; r++) begin
      y = x ^ m_rotl(KEY, 7 * r) ^ {96'b0, r[31:0]};
      x = y ^ (m_rotl(y, 1) & m_rotl(y, 8)) ^ m_rotl(y, 2);
    end
    return x;
  endfunction

  function automatic logic [127:0] m_h(logic [127:0] x, logic [32:0] t);
    logic [127:0] z;
    z = {x[126:0], 1'b0} ^ {95'b0, t};
    return m_enc(z) ^ z;
  endfunction

  function automatic logic [127:0] m_eval(logic nlin, logic [31:0] j, logic [127:0] a,
                                          logic [127:0] b, logic [127:0] tg, logic [127:0] te);
    logic [127:0] g, e;
    if (!nlin) return a ^ b;
    g = m_h(a, {j, 1'b0}) ^ (a[0] ? tg : 128'b0);
    e = m_h(b, {j, 1'b1}) ^ (b[0] ? (te ^ a) : 128'b0);
    return g ^ e;
  endfunction

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // batch queue
  logic         q_nl  [64];
  logic [31:0]  q_j   [64];
  logic [15:0]  q_dst [64];
  logic [127:0] q_a [64], q_b [64], q_tg [64], q_te [64], q_exp [64];
  int n = 0;

  task automatic push(logic nlin, logic [31:0] j, logic [127:0] a, logic [127:0] b,
                      logic [127:0] tg, logic [127:0] te, logic [127:0] exp);
    q_nl[n] = nlin; q_j[n] = j; q_dst[n] = 16'(($urandom % 65536));
    q_a[n] = a; q_b[n] = b; q_tg[n] = tg; q_te[n] = te; q_exp[n] = exp;
    n++;
  endtask

  // drive gates back to back and check every cycle of the stream
  task automatic run_batch(string req);
    int g;
    for (int c = 0; c <= n + LAT; c++) begin
      @(negedge clk);
      g = c - LAT;
      if (g >= 0 && g < n) begin
        check("R5", {req, " valid"}, 128'(out_valid), 128'(1));
        check(req, "label", out_lbl, q_exp[g]);
        check("R7", {req, " dst"}, 128'(out_dst), 128'(q_dst[g]));
        check("R7", {req, " kind"}, 128'(out_nonlin), 128'(q_nl[g]));
      end else begin
        check("R5", {req, " idle"}, 128'(out_valid), 128'(0));
      end
      if (c < n) begin
        in_valid = 1'b1; in_nonlin = q_nl[c]; in_gidx = q_j[c]; in_dst = q_dst[c];
        in_lbl_a = q_a[c]; in_lbl_b = q_b[c]; in_tbl_g = q_tg[c]; in_tbl_e = q_te[c];
      end else begin
        in_valid = 1'b0; in_lbl_a = r128(); in_tbl_g = r128();
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8", "valid in reset", 128'(out_valid), 128'(0));
    check("R8", "label in reset", out_lbl, 128'(0));
    check("R8", "dst in reset", 128'(out_dst), 128'(0));
    check("R8", "kind in reset", 128'(out_nonlin), 128'(0));
  endtask

  task automatic t_xor();
    logic [127:0] a, b;
    n = 0;
    a = r128(); b = r128();
    // R1: identical labels, different tables and index -> same result
    push(1'b0, $urandom, a, b, r128(), r128(), a ^ b);
    push(1'b0, $urandom, a, b, r128(), r128(), a ^ b);
    push(1'b0, 32'hffff_ffff, '1, '0, '1, '1, '1);
    push(1'b0, 32'd0, a, a, r128(), r128(), '0);
    run_batch("R1");
  endtask

  task automatic t_half();
    logic [127:0] a, b, tg, te;
    logic [31:0] j;
    n = 0;
    // R4: all four select-bit combinations; R3: index extremes for the tweak
    for (int k = 0; k < 8; k++) begin
      a = r128(); b = r128(); tg = r128(); te = r128();
      a[0] = k[0]; b[0] = k[1];
      j = (k == 6) ? 32'hffff_ffff : ((k == 7) ? 32'd0 : $urandom);
      push(1'b1, j, a, b, tg, te, m_eval(1'b1, j, a, b, tg, te));
    end
    run_batch("R2");
    // R4: select bits clear -> tables have no effect
    n = 0;
    a = r128(); b = r128(); a[0] = 1'b0; b[0] = 1'b0; j = $urandom;
    push(1'b1, j, a, b, r128(), r128(), m_h(a, {j, 1'b0}) ^ m_h(b, {j, 1'b1}));
    push(1'b1, j, a, b, '1, '1, m_h(a, {j, 1'b0}) ^ m_h(b, {j, 1'b1}));
    run_batch("R4");
  endtask

  task automatic t_mixed();
    logic [127:0] a, b, tg, te;
    logic [31:0] j;
    logic nlin;
    n = 0;
    for (int k = 0; k < 24; k++) begin
      a = r128(); b = r128(); tg = r128(); te = r128(); j = $urandom;
      nlin = (k % 3) != 1;
      push(nlin, j, a, b, tg, te, m_eval(nlin, j, a, b, tg, te));
    end
    run_batch("R6");
  endtask

  task automatic t_garble();
    logic [127:0] delta, a0, b0, tg, te, w0, ha0, hb0, a, b;
    logic [31:0] j;
    n = 0;
    delta = r128(); delta[0] = 1'b1;
    a0 = r128(); b0 = r128(); j = $urandom;
    ha0 = m_h(a0, {j, 1'b0});
    hb0 = m_h(b0, {j, 1'b1});
    tg = ha0 ^ m_h(a0 ^ delta, {j, 1'b0}) ^ (b0[0] ? delta : 128'b0);
    te = hb0 ^ m_h(b0 ^ delta, {j, 1'b1}) ^ a0;
    w0 = (ha0 ^ (a0[0] ? tg : 128'b0)) ^ (hb0 ^ (b0[0] ? (te ^ a0) : 128'b0));
    for (int v = 0; v < 4; v++) begin
      a = v[0] ? (a0 ^ delta) : a0;
      b = v[1] ? (b0 ^ delta) : b0;
      push(1'b1, j, a, b, tg, te, (v == 3) ? (w0 ^ delta) : w0);
    end
    run_batch("R10");
  endtask

  task automatic t_hold();
    logic [127:0] lastl;
    logic [15:0] lastd;
    lastl = out_lbl; lastd = out_dst;
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_lbl_a = r128(); in_lbl_b = r128(); in_dst = 16'($urandom);
      check("R9", "label held", out_lbl, lastl);
      check("R9", "dst held", 128'(out_dst), 128'(lastd));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(10 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_xor();
    t_half();
    t_mixed();
    t_garble();
    t_hold();
    finish_run();
  end
endmodule